// File: doc/BRIEF.md
# Fetch-Decode-Execute Sequencer with Flush and Interrupt Entry

This block moves instruction words through a three-slot pipeline (fetch, decode, execute) for a small 32-bit load/store core. It presents a word-aligned fetch address to instruction memory. Each returned word travels one slot per clock, together with the address it was fetched from. The execute slot shows its instruction along with the PC value that instruction must see, which is its own address plus 8. The datapath that acts on the instruction sits outside. It reports back through two plain pins: a PC-write request and the new target.

Two events discard the younger slots. The first is a taken branch or PC write from an instruction in execute; fetch then restarts at the aligned target. The second is an accepted interrupt; fetch then restarts at a fixed handler entry address. In both cases the instruction already in execute completes. An interrupt also reports the address where the interrupted program resumes.

Instruction memory returns words on a valid-only channel. Each cycle the block drives `fetch_addr`. In any cycle where `imem_valid` is high, `imem_rdata` is taken as the word at that address and the address steps by 4. While `imem_valid` is low, the address is held and a bubble enters decode. The block never pushes back on memory. Decode and execute never stall, so the block has no ready output.

Top module: `fde_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the decode and execute valid bits and the pending interrupt, and sets `fetch_addr` to 0.
- R2: `fetch_addr` always has its two low bits at zero. It rises by 4 after each cycle in which `imem_valid` is high and no flush occurs. It is unchanged after a cycle in which `imem_valid` is low and no flush occurs.
- R3: A word accepted in cycle t, if no flush intervenes, is in decode during cycle t+1 and in execute during cycle t+2, with the same instruction value.
- R4: While `x_valid` is high, `x_pc_view` equals the fetch address of the execute instruction plus 8.
- R5: If `ex_redirect` is high while `x_valid` is high, then in the next cycle `fetch_addr` equals `ex_target` with its two low bits cleared, and decode and execute are both invalid. Execute stays invalid for exactly two cycles after the redirect, assuming memory answers at once.
- R6: `ex_redirect` has no effect while `x_valid` is low.
- R7: A taken interrupt raises `irq_ack` for that one cycle. In that cycle `irq_ret_addr` equals the execute address plus 4. In the next cycle `fetch_addr` equals the vector address and decode and execute are invalid.
- R8: While `irq_en` is low, no interrupt is taken. A request seen while masked is kept pending and is taken once `irq_en` is high and `x_valid` is high, even if `irq_req` has fallen.
- R9: When an interrupt and a redirect happen in the same cycle, `irq_ret_addr` equals the aligned `ex_target`, and fetch goes to the vector address.
- R10: No interrupt is taken while `x_valid` is low. A request that arrives in such a cycle stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | output | 32 | Instruction fetch address, word aligned |
| imem_valid | input | 1 | Memory word on `imem_rdata` is valid this cycle |
| imem_rdata | input | 32 | Instruction word at `fetch_addr` |
| f_valid | output | 1 | Fetched word is kept (valid and no flush this cycle) |
| f_instr | output | 32 | Word in the fetch slot |
| d_valid | output | 1 | Decode slot holds an instruction |
| d_instr | output | 32 | Decode slot instruction |
| x_valid | output | 1 | Execute slot holds an instruction |
| x_instr | output | 32 | Execute slot instruction |
| x_pc_view | output | 32 | PC seen by the execute instruction (its address + 8) |
| ex_redirect | input | 1 | Execute instruction writes the PC or takes a branch |
| ex_target | input | 32 | New PC for the redirect |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable; low masks requests |
| irq_ack | output | 1 | Interrupt taken this cycle |
| irq_ret_addr | output | 32 | Resume address, valid with `irq_ack` |

## Verification
The bench checks the bubble count after a redirect. A design that kept the decode slot would let a wrong-path instruction execute, and one that cleared too little would show a valid execute one cycle early. It drives a redirect into an empty execute slot, where a design that does not qualify the redirect would jump anyway. It holds a request while the mask is low and while execute is empty. A design that drops the pending request, or takes it with no completing instruction, shows either no `irq_ack` or a wrong resume address. It also lines a redirect up with an interrupt. A design that gives priority the wrong way saves the fall-through address, or fetches the branch target instead of the vector.

// File: rtl/fde_pkg.sv
package fde_pkg;
  parameter int unsigned WORD_W   = 32;
  parameter int unsigned WORD_B   = WORD_W / 8;
  parameter int unsigned ALIGN_W  = $clog2(WORD_B);
  parameter int unsigned VIEW_OFS = 2 * WORD_B;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  valid;
    word_t instr;
    word_t addr;
  } slot_t;

  function automatic word_t align_word(input word_t a);
    word_t m;
    m = '1;
    m[ALIGN_W-1:0] = '0;
    return a & m;
  endfunction
endpackage

// File: rtl/fde_fetch_pc.sv
module fde_fetch_pc
  import fde_pkg::*;
#(
  parameter word_t RESET_ADDR = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  jump,
  input  word_t jump_addr,
  output word_t pc
);
  word_t pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= align_word(RESET_ADDR);
    else if (jump)   pc_q <= align_word(jump_addr);
    else if (accept) pc_q <= pc_q + word_t'(WORD_B);
  end

  assign pc = pc_q;
endmodule

// File: rtl/fde_slot_reg.sv
module fde_slot_reg
  import fde_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  slot_t d,
  output slot_t q
);
  slot_t q_r;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      q_r.valid <= 1'b0;
      q_r.instr <= d.instr;
      q_r.addr  <= d.addr;
    end else begin
      q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/fde_irq_ctrl.sv
module fde_irq_ctrl
  import fde_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  enable,
  input  logic  exec_valid,
  input  word_t exec_addr,
  input  logic  redir,
  input  word_t redir_addr,
  output logic  take,
  output word_t ret_addr
);
  logic pend_q;
  logic want;

  assign want     = pend_q | req;
  assign take     = want & enable & exec_valid;
  assign ret_addr = redir ? align_word(redir_addr) : exec_addr + word_t'(WORD_B);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & ~take;
  end
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
  import fde_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR  = 32'h0000_0000,
  parameter logic [31:0] VECTOR_ADDR = 32'h0000_0018
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] fetch_addr,
  input  logic        imem_valid,
  input  logic [31:0] imem_rdata,
  output logic        f_valid,
  output logic [31:0] f_instr,
  output logic        d_valid,
  output logic [31:0] d_instr,
  output logic        x_valid,
  output logic [31:0] x_instr,
  output logic [31:0] x_pc_view,
  input  logic        ex_redirect,
  input  logic [31:0] ex_target,
  input  logic        irq_req,
  input  logic        irq_en,
  output logic        irq_ack,
  output logic [31:0] irq_ret_addr
);
  localparam int unsigned NSLOT = 3;
  localparam int unsigned XSLOT = NSLOT - 1;

  slot_t slot [NSLOT];
  word_t pc;
  logic  redir;
  logic  take;
  logic  flush;
  word_t jump_addr;

  assign redir     = slot[XSLOT].valid & ex_redirect;
  assign flush     = redir | take;
  assign jump_addr = take ? VECTOR_ADDR : ex_target;

  fde_fetch_pc #(.RESET_ADDR(RESET_ADDR)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (imem_valid),
    .jump      (flush),
    .jump_addr (jump_addr),
    .pc        (pc)
  );

  assign slot[0] = '{valid: imem_valid, instr: imem_rdata, addr: pc};

  for (genvar g = 1; g < NSLOT; g++) begin : g_slot
    fde_slot_reg u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (flush),
      .d     (slot[g-1]),
      .q     (slot[g])
    );
  end

  fde_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (irq_req),
    .enable     (irq_en),
    .exec_valid (slot[XSLOT].valid),
    .exec_addr  (slot[XSLOT].addr),
    .redir      (redir),
    .redir_addr (ex_target),
    .take       (take),
    .ret_addr   (irq_ret_addr)
  );

  assign fetch_addr = pc;
  assign f_valid    = slot[0].valid & ~flush;
  assign f_instr    = slot[0].instr;
  assign d_valid    = slot[1].valid;
  assign d_instr    = slot[1].instr;
  assign x_valid    = slot[XSLOT].valid;
  assign x_instr    = slot[XSLOT].instr;
  assign x_pc_view  = slot[XSLOT].addr + word_t'(VIEW_OFS);
  assign irq_ack    = take;
endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk
  import fde_pkg::*;
#(
  parameter logic [31:0] VECTOR_ADDR = 32'h0000_0018
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fetch_addr,
  input logic        imem_valid,
  input logic        d_valid,
  input logic [31:0] d_instr,
  input logic        x_valid,
  input logic [31:0] x_instr,
  input logic [31:0] x_pc_view,
  input logic        ex_redirect,
  input logic [31:0] ex_target,
  input logic        irq_en,
  input logic        irq_ack,
  input logic [31:0] irq_ret_addr
);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[ALIGN_W-1:0] == '0);

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !imem_valid && !ex_redirect && !irq_ack |=> $stable(fetch_addr));

  // R3
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !(x_valid && ex_redirect) && !irq_ack |=> x_valid && x_instr == $past(d_instr));

  // R5
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid && ex_redirect && !irq_ack |=>
      !d_valid && !x_valid && fetch_addr == align_word($past(ex_target)));

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !d_valid && !x_valid |=> !x_valid);

  // R7
  vector_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> fetch_addr == VECTOR_ADDR && !d_valid && !x_valid);

  // R7
  resume_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !ex_redirect |-> irq_ret_addr == x_pc_view - word_t'(WORD_B));

  // R8
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_ack);

  // R9
  both_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && ex_redirect |-> irq_ret_addr == align_word(ex_target));

  // R10
  needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> x_valid);
endmodule

bind fde_sequencer fde_sequencer_chk #(.VECTOR_ADDR(VECTOR_ADDR)) u_chk (.*);

// File: tb/test_fde_sequencer.sv
`timescale 1ns/1ps
module test_fde_sequencer;
  localparam logic [31:0] VEC = 32'h0000_0018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr;
  logic        imem_valid = 1'b0;
  logic [31:0] imem_rdata;
  logic        f_valid, d_valid, x_valid, irq_ack;
  logic [31:0] f_instr, d_instr, x_instr, x_pc_view, irq_ret_addr;
  logic        ex_redirect = 1'b0;
  logic [31:0] ex_target = '0;
  logic        irq_req = 1'b0;
  logic        irq_en = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0};
  endfunction

  assign imem_rdata = mem_word(fetch_addr);

  fde_sequencer #(.RESET_ADDR(32'h0), .VECTOR_ADDR(VEC)) i_fde_sequencer (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .imem_valid(imem_valid), .imem_rdata(imem_rdata),
    .f_valid(f_valid), .f_instr(f_instr),
    .d_valid(d_valid), .d_instr(d_instr),
    .x_valid(x_valid), .x_instr(x_instr), .x_pc_view(x_pc_view),
    .ex_redirect(ex_redirect), .ex_target(ex_target),
    .irq_req(irq_req), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq_ret_addr(irq_ret_addr)
  );

  // behavioural reference state
  logic [31:0] m_pc;
  bit          m_dv, m_xv, m_pend, m_init;
  logic [31:0] m_di, m_dp, m_xi, m_xp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit rdy, input bit rd, input logic [31:0] tgt, input bit rq, input bit en);
    imem_valid = rdy; ex_redirect = rd; ex_target = tgt; irq_req = rq; irq_en = en;
    #1;
  endtask

  // compare against the reference, then advance one clock
  task automatic tick();
    bit redir, take;
    logic [31:0] al;
    al    = {ex_target[31:2], 2'b00};
    redir = m_xv && ex_redirect;
    take  = irq_en && m_xv && (m_pend || irq_req);
    if (rst_n && m_init) begin
      chk(fetch_addr == m_pc, "R2 fetch_addr", fetch_addr, m_pc);
      chk(f_valid == (imem_valid && !(redir || take)), "R2 f_valid", 32'(f_valid), 32'(imem_valid && !(redir || take)));
      chk(d_valid == m_dv, "R3 d_valid", 32'(d_valid), 32'(m_dv));
      if (m_dv) chk(d_instr == m_di, "R3 d_instr", d_instr, m_di);
      chk(x_valid == m_xv, "R3 x_valid", 32'(x_valid), 32'(m_xv));
      if (m_xv) begin
        chk(x_instr == m_xi, "R3 x_instr", x_instr, m_xi);
        chk(x_pc_view == m_xp + 32'd8, "R4 x_pc_view", x_pc_view, m_xp + 32'd8);
      end
      chk(irq_ack == take, "R7 irq_ack", 32'(irq_ack), 32'(take));
      if (take)
        chk(irq_ret_addr == (redir ? al : m_xp + 32'd4), "R7 irq_ret_addr",
            irq_ret_addr, redir ? al : m_xp + 32'd4);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_pc = 32'h0; m_dv = 0; m_xv = 0; m_pend = 0; m_init = 1;
    end else begin
      m_pend = (m_pend || irq_req) && !take;
      if (take || redir) begin
        m_pc = take ? VEC : al;
        m_dv = 0; m_xv = 0;
      end else begin
        m_xv = m_dv; m_xi = m_di; m_xp = m_dp;
        m_dv = imem_valid; m_di = mem_word(m_pc); m_dp = m_pc;
        if (imem_valid) m_pc = m_pc + 32'd4;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_init = 0;
    @(negedge clk);
    rst_n = 0;
    drive(1, 0, 0, 0, 0); tick(); tick();
    rst_n = 1;
    drive(1, 0, 0, 0, 0);
    // R1 reset state
    chk(fetch_addr == 0, "R1 fetch_addr", fetch_addr, 0);
    chk(!d_valid && !x_valid, "R1 valids", {d_valid, x_valid}, 0);
    tick(); tick();
    // R3/R4 first word reaches execute two cycles after fetch
    chk(x_valid && x_instr == mem_word(0), "R3 first exec", x_instr, mem_word(0));
    chk(x_pc_view == 32'd8, "R4 view", x_pc_view, 32'd8);
    // R5 redirect with unaligned target
    drive(1, 1, 32'h203, 0, 0); tick();
    chk(fetch_addr == 32'h200, "R5 target", fetch_addr, 32'h200);
    chk(!d_valid && !x_valid, "R5 flush", {d_valid, x_valid}, 0);
    // R6 redirect into empty execute ignored
    drive(1, 1, 32'h400, 0, 0); tick();
    chk(fetch_addr == 32'h204, "R6 ignored", fetch_addr, 32'h204);
    chk(d_valid && !x_valid, "R5 second bubble", {d_valid, x_valid}, 2'b10);
    drive(1, 0, 0, 0, 0); tick();
    chk(x_valid && x_pc_view == 32'h208, "R5 refill", x_pc_view, 32'h208);
    // R2 hold while memory not valid
    drive(0, 0, 0, 0, 0); tick(); tick();
    chk(fetch_addr == 32'h208, "R2 hold", fetch_addr, 32'h208);
    drive(1, 0, 0, 0, 0); tick(); tick(); tick();
    // R8 masked request stays pending
    drive(1, 0, 0, 1, 0);
    chk(!irq_ack, "R8 masked", 32'(irq_ack), 0);
    tick();
    drive(1, 0, 0, 0, 0); tick();
    drive(1, 0, 0, 0, 1);
    chk(irq_ack && irq_ret_addr == m_xp + 32'd4, "R8 pending taken", irq_ret_addr, m_xp + 32'd4);
    tick();
    chk(fetch_addr == VEC && !d_valid && !x_valid, "R7 vector", fetch_addr, VEC);
    // R10 no take while execute empty, request stays pending
    drive(1, 0, 0, 1, 1);
    chk(!irq_ack, "R10 empty exec", 32'(irq_ack), 0);
    tick();
    drive(1, 0, 0, 0, 1);
    chk(!irq_ack, "R10 still empty", 32'(irq_ack), 0);
    tick();
    drive(1, 0, 0, 0, 1);
    chk(irq_ack && irq_ret_addr == VEC + 32'd4, "R10 pending taken", irq_ret_addr, VEC + 32'd4);
    tick();
    drive(1, 0, 0, 0, 0); tick(); tick();
    // R9 redirect and interrupt together
    drive(1, 1, 32'h301, 1, 1);
    chk(irq_ack && irq_ret_addr == 32'h300, "R9 ret", irq_ret_addr, 32'h300);
    tick();
    chk(fetch_addr == VEC, "R9 vector", fetch_addr, VEC);
    // mixed traffic against the reference
    for (int i = 0; i < 2000; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 8) == 0, $urandom,
            ($urandom % 10) == 0, ($urandom % 2) == 0);
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule